// File: doc/BRIEF.md
# Strobed Burst Receiver with Per-Burst CRC

This block is the receiving end of a source-synchronous parallel burst link. The sender toggles a strobe line, and every transition carries one 16-bit word, whether the strobe rises or falls. The receiver samples the strobe and data through a short synchronizer and detects each strobe transition. It pushes each captured word into a small elastic FIFO that the core drains with a valid/take handshake.

The receiver does not acknowledge individual words. It throttles the sender only through a ready output, which it drops while the FIFO still has enough room to absorb the words already in flight. Every captured word also goes through a 16-bit CRC that restarts at the beginning of each burst. When the sender delivers its own CRC word at the end of a burst, the receiver compares it with its running value. On a mismatch it sets a sticky error flag, which stays set until an explicit clear.

Top module: `strobe_burst_rx`

## Requirements
- R1: After reset the FIFO is empty (`out_vld_o` low), `rdy_o` is high and `err_o` is low.
- R2: While `burst_i` is high, every change of `strb_i` (low-to-high and high-to-low alike) captures `data_i` as one word. Words leave on `out_data_o` in arrival order. A word is removed in a cycle where `out_vld_o` and `out_take_i` are both high.
- R3: `rdy_o` is high exactly while the FIFO holds fewer than DEPTH-SLACK words (with the defaults DEPTH=8 and SLACK=4, it goes low at 4 stored words). The words still arriving after `rdy_o` falls, up to 3 of them, are all stored, and no write is ever made to a full FIFO.
- R4: Words spaced two clock cycles apart are all accepted without per-word flow control. While the core drains the FIFO, `rdy_o` stays high.
- R5: Strobe transitions while `burst_i` is low capture nothing and leave the CRC unchanged.
- R6: The CRC restarts at the seed 16'hFFFF in the cycle after `burst_i` rises. It is updated once per captured word, taking all 16 data bits MSB first with the polynomial x^16+x^12+x^5+1 (16'h1021).
- R7: A pulse on `crc_chk_i` compares `crc_word_i` with the running CRC. A mismatch sets `err_o` in the next cycle, a match leaves it unchanged, and once set `err_o` stays set.
- R8: `err_clr_i` clears `err_o` in the next cycle. When a mismatch and a clear occur in the same cycle, the flag is set.
- R9: The CRC does not carry over between bursts. A burst checked with the CRC of its own words alone reports no error, whatever came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_i | input | 1 | High for the duration of a burst |
| strb_i | input | 1 | Sender strobe, one word per transition |
| data_i | input | W (16) | Sender data word |
| rdy_o | output | 1 | High when the sender may keep sending |
| crc_chk_i | input | 1 | One-cycle pulse: the sender CRC word is present |
| crc_word_i | input | 16 | CRC word delivered by the sender |
| err_clr_i | input | 1 | Clears the sticky CRC error flag |
| err_o | output | 1 | Sticky CRC mismatch flag |
| out_vld_o | output | 1 | FIFO holds at least one word |
| out_data_o | output | W (16) | Oldest stored word |
| out_take_i | input | 1 | Core removes the oldest word |

## Verification
The bound checker watches the following on every cycle: that no captured word lands in a full FIFO, that the occupancy moves by exactly one on a lone write or a lone removal, that the CRC sits at its seed right after a burst opens, and how the error flag responds to mismatch, hold and clear. Other behaviour depends on the sequence of stimulus and is shown only by the bench's scenarios. These are the data order through the FIFO, the exact occupancy at which ready falls, the three late words absorbed after that, and strobes ignored outside a burst. The bench also compares the CRC against an arithmetic model, sweeping burst lengths from zero to nine words across several data patterns and strobe spacings.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_DEF = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED_DEF = 16'hFFFF;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sbr_edge_capture.sv
module sbr_edge_capture
  import sbr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         strb_i,
  input  logic [W-1:0] data_i,
  output logic         word_vld_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned S = SYNC_STAGES;

  logic [S-1:0] strb_q, strb_d;
  logic [W-1:0] data_q [S];
  logic [W-1:0] data_d [S];
  logic         last_q, last_d;

  // next-state: shift strobe and data through matched stages
  always_comb begin
    strb_d    = {strb_q[S-2:0], strb_i};
    data_d[0] = data_i;
    for (int k = 1; k < S; k++) begin
      data_d[k] = data_q[k-1];
    end
    last_d = strb_q[S-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      last_q <= 1'b0;
      for (int k = 0; k < S; k++) begin
        data_q[k] <= '0;
      end
    end else begin
      strb_q <= strb_d;
      last_q <= last_d;
      for (int k = 0; k < S; k++) begin
        data_q[k] <= data_d[k];
      end
    end
  end

  // any transition of the synchronized strobe marks one word
  assign word_vld_o = en_i && (strb_q[S-1] != last_q);
  assign word_o     = data_q[S-1];
endmodule

// File: rtl/sbr_fifo.sv
module sbr_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [W-1:0]               wr_data_i,
  input  logic                       rd_i,
  output logic [W-1:0]               rd_data_o,
  output logic                       vld_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign vld_o   = (cnt_q != '0);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && vld_o;
  assign count_o = cnt_q;
  assign rd_data_o = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage needs no reset; written before it is read
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data_i;
  end
endmodule

// File: rtl/sbr_crc_check.sv
module sbr_crc_check
  import sbr_pkg::*;
#(
  parameter int unsigned      W    = 16,
  parameter logic [CRC_W-1:0] POLY = CRC_POLY_DEF,
  parameter logic [CRC_W-1:0] SEED = CRC_SEED_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             upd_i,
  input  logic [W-1:0]     word_i,
  input  logic             chk_i,
  input  logic [CRC_W-1:0] chk_word_i,
  input  logic             clr_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             err_o
);
  logic [CRC_W-1:0] crc_q, crc_d, base, acc;
  logic             err_q, err_d, fb, mismatch;

  // serial division unrolled over every data bit, MSB first
  always_comb begin
    base = start_i ? SEED : crc_q;
    acc  = base;
    fb   = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ word_i[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_d = upd_i ? acc : base;
  end

  assign mismatch = chk_i && (chk_word_i != crc_q);

  // set takes priority over clear
  always_comb begin
    if (mismatch)   err_d = 1'b1;
    else if (clr_i) err_d = 1'b0;
    else            err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= SEED;
      err_q <= 1'b0;
    end else begin
      crc_q <= crc_d;
      err_q <= err_d;
    end
  end

  assign crc_o = crc_q;
  assign err_o = err_q;
endmodule

// File: rtl/strobe_burst_rx.sv
module strobe_burst_rx
  import sbr_pkg::*;
#(
  parameter int unsigned      W        = 16,
  parameter int unsigned      DEPTH    = 8,
  parameter int unsigned      SLACK    = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = CRC_POLY_DEF,
  parameter logic [CRC_W-1:0] CRC_SEED = CRC_SEED_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_i,
  input  logic             strb_i,
  input  logic [W-1:0]     data_i,
  output logic             rdy_o,
  input  logic             crc_chk_i,
  input  logic [CRC_W-1:0] crc_word_i,
  input  logic             err_clr_i,
  output logic             err_o,
  output logic             out_vld_o,
  output logic [W-1:0]     out_data_o,
  input  logic             out_take_i
);
  localparam int unsigned CNT_W  = $clog2(DEPTH+1);
  localparam int unsigned RDY_LIM = DEPTH - SLACK;

  logic             burst_q, burst_start;
  logic             cap_vld;
  logic [W-1:0]     cap_word;
  logic             fifo_full;
  logic [CNT_W-1:0] fifo_count;
  logic [CRC_W-1:0] crc_val;
  logic             pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_i;
  end
  assign burst_start = burst_i && !burst_q;

  sbr_edge_capture #(.W(W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (burst_i),
    .strb_i    (strb_i),
    .data_i    (data_i),
    .word_vld_o(cap_vld),
    .word_o    (cap_word)
  );

  assign pop = out_take_i && out_vld_o;

  sbr_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cap_vld),
    .wr_data_i(cap_word),
    .rd_i     (out_take_i),
    .rd_data_o(out_data_o),
    .vld_o    (out_vld_o),
    .full_o   (fifo_full),
    .count_o  (fifo_count)
  );

  // room for SLACK more words remains when ready drops
  assign rdy_o = (fifo_count < CNT_W'(RDY_LIM));

  sbr_crc_check #(.W(W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (burst_start),
    .upd_i     (cap_vld),
    .word_i    (cap_word),
    .chk_i     (crc_chk_i),
    .chk_word_i(crc_word_i),
    .clr_i     (err_clr_i),
    .crc_o     (crc_val),
    .err_o     (err_o)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int unsigned CW    = 4,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fire,
  input logic          full,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          start,
  input logic [15:0]   crc,
  input logic          chk,
  input logic [15:0]   word,
  input logic          clr,
  input logic          err
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !full);

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pop && !full) |=> count == $past(count) + 1'b1);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !fire) |=> count == $past(count) - 1'b1);

  p_crc_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fire) |=> crc == SEED);

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && word != crc) |=> err);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(chk && word != crc)) |=> !err);
endmodule

bind strobe_burst_rx sbr_checker #(.CW(CNT_W), .SEED(CRC_SEED)) u_sbr_checker (
  .clk  (clk),
  .rst_n(rst_n),
  .fire (cap_vld),
  .full (fifo_full),
  .pop  (pop),
  .count(fifo_count),
  .start(burst_start),
  .crc  (crc_val),
  .chk  (crc_chk_i),
  .word (crc_word_i),
  .clr  (err_clr_i),
  .err  (err_o)
);

// File: tb/strobe_burst_rx_bench.sv
`timescale 1ns/1ps
module strobe_burst_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst = 1'b0;
  logic        strb = 1'b0;
  logic [15:0] data = '0;
  logic        rdy;
  logic        chk = 1'b0;
  logic [15:0] chk_word = '0;
  logic        clr = 1'b0;
  logic        err;
  logic        vld;
  logic [15:0] dout;
  logic        take = 1'b0;

  int tests = 0;
  int fails = 0;
  bit drain_en = 1'b0;
  bit rdy_low_seen = 1'b0;
  bit done = 1'b0;
  logic [15:0] expq[$];
  logic [15:0] crc_m;

  always #2 clk = ~clk;

  strobe_burst_rx u_strobe_burst_rx (
    .clk(clk), .rst_n(rst_n), .burst_i(burst), .strb_i(strb), .data_i(data),
    .rdy_o(rdy), .crc_chk_i(chk), .crc_word_i(chk_word), .err_clr_i(clr),
    .err_o(err), .out_vld_o(vld), .out_data_o(dout), .out_take_i(take)
  );

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c ^ d;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // core side: take a word whenever one is offered and compare it (R2)
  always @(negedge clk) begin
    if (drain_en && vld) begin
      if (expq.size() == 0) check("R2/R5 unexpected word", dout, 16'hxxxx);
      else check("R2 word order", dout, expq.pop_front());
      take = 1'b1;
    end else begin
      take = 1'b0;
    end
    if (drain_en && burst && !rdy) rdy_low_seen = 1'b1;
  end

  task automatic send_word(input logic [15:0] w, input int gap);
    data = w;
    strb = ~strb;
    expq.push_back(w);
    crc_m = model_crc(crc_m, w);
    repeat (gap) @(negedge clk);
  endtask

  task automatic open_burst();
    burst = 1'b1;
    crc_m = 16'hFFFF;
    repeat (2) @(negedge clk);
  endtask

  // end burst, deliver CRC word (optionally corrupted), return flag
  task automatic close_and_check(input bit corrupt, input bit exp_err, input string req);
    repeat (5) @(negedge clk);
    burst = 1'b0;
    chk = 1'b1;
    chk_word = corrupt ? (crc_m ^ 16'h0001) : crc_m;
    @(negedge clk);
    chk = 1'b0;
    check(req, {15'b0, err}, {15'b0, exp_err});
  endtask

  task automatic clear_err();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 vld", {15'b0, vld}, 16'h0);
    check("R1 rdy", {15'b0, rdy}, 16'h1);
    check("R1 err", {15'b0, err}, 16'h0);

    // R2 R4 R6 R7 R9: sweep of burst length, pattern and spacing
    drain_en = 1'b1;
    for (int len = 0; len < 10; len++) begin
      for (int p = 0; p < 3; p++) begin
        int gap;
        gap = (p == 1) ? 3 : 2;
        rdy_low_seen = 1'b0;
        open_burst();
        for (int i = 0; i < len; i++) begin
          logic [15:0] w;
          if (p == 2) w = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
          else w = 16'((len * 4099) + (i * 777 * (p + 1)) + ((i ^ p) * 13));
          send_word(w, gap);
        end
        check("R4 rdy held high", {15'b0, rdy_low_seen}, 16'h0);
        if (p == 2 && len % 2 == 1) begin
          close_and_check(1'b1, 1'b1, "R7 mismatch sets flag");
          repeat (3) @(negedge clk);
          check("R7 flag sticky", {15'b0, err}, 16'h1);
          clear_err();
          check("R8 clear", {15'b0, err}, 16'h0);
        end else begin
          close_and_check(1'b0, 1'b0, "R6 R9 matching crc");
        end
        check("R2 all words drained", 16'(expq.size()), 16'h0);
      end
    end

    // R3: stall the core, count words until ready falls, then 3 late words
    drain_en = 1'b0;
    open_burst();
    begin
      int sent;
      sent = 0;
      while (rdy && sent < 8) begin
        send_word(16'hA500 + 16'(sent), 4);
        sent++;
      end
      check("R3 ready threshold", 16'(sent), 16'd4);
      for (int j = 0; j < 3; j++) send_word(16'h5A00 + 16'(j), 2);
      repeat (5) @(negedge clk);
      check("R3 ready still low", {15'b0, rdy}, 16'h0);
    end
    drain_en = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 late words stored", 16'(expq.size()), 16'h0);
    check("R3 ready restored", {15'b0, rdy}, 16'h1);
    close_and_check(1'b0, 1'b0, "R3 crc over stalled burst");

    // R5: strobes outside a burst are ignored by FIFO and CRC
    open_burst();
    send_word(16'h1234, 2);
    send_word(16'hBEEF, 2);
    repeat (5) @(negedge clk);
    burst = 1'b0;
    for (int j = 0; j < 4; j++) begin
      data = 16'h7700 + 16'(j);
      strb = ~strb;
      repeat (2) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check("R5 no capture", {15'b0, vld}, 16'h0);
    close_and_check(1'b0, 1'b0, "R5 crc unchanged");

    // R8: mismatch and clear in the same cycle, set wins
    open_burst();
    send_word(16'h0F0F, 2);
    repeat (5) @(negedge clk);
    burst = 1'b0;
    chk = 1'b1;
    clr = 1'b1;
    chk_word = crc_m ^ 16'h8000;
    @(negedge clk);
    chk = 1'b0;
    clr = 1'b0;
    check("R8 set wins over clear", {15'b0, err}, 16'h1);
    clear_err();
    check("R8 clear after", {15'b0, err}, 16'h0);

    // R9: burst after an errored one checks cleanly on its own CRC
    open_burst();
    send_word(16'hCAFE, 2);
    send_word(16'h0001, 3);
    close_and_check(1'b0, 1'b0, "R9 crc restarts per burst");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule